// File: doc/BRIEF.md
# Load-String-Word Register Sequencer

This block carries out the multi-cycle part of a load-string-word operation in a simple 64-bit big-endian core. A one-cycle start pulse arrives with the decoded fields: the first target register, the base and index register numbers and the values read from them, a 5-bit immediate count, a 7-bit count from the fixed-point exception register, a form select and the current endian mode. The block latches the effective address and the byte count. It then fetches one byte at a time over a byte-wide request/response memory port and packs the bytes into consecutive general registers through a single register-file write port.

Each register receives a 32-bit word in its low half, with the first byte in the most significant position. The upper half is written as zero. Register numbers wrap from 31 to 0. A write that would land on the register that supplied the address is dropped. In little-endian mode the operation stops at once with an alignment exception.

Top module: `strload_seq`

## Requirements
- R1: Immediate form (`formIdx`=0): the effective address is `raVal`, or 0 when `raIdx` is 0. The byte count is `immCount`, and a value of 0 means 32 bytes.
- R2: Indexed form (`formIdx`=1): the effective address is (`raVal`, or 0 when `raIdx` is 0) plus `rbVal`. The byte count is `xerCount`.
- R3: Byte k of the string is the memory byte at address EA+k. It goes to word k/4, at bits [31-8*(k%4) -: 8] of the write data. Bits [63:32] of every register write are zero.
- R4: When the last word holds fewer than 4 bytes, its remaining low-order byte positions are written as zero.
- R5: Register numbers advance from `rtIdx` by one per word and wrap from 31 to 0.
- R6: A count of n produces at most ceil(n/4) register writes, one per word in order, and no other writes.
- R7: The write for a word whose register equals `rbIdx` (indexed form), or equals a nonzero `raIdx` (immediate form), is suppressed. The sequence still continues with the next register.
- R8: With `littleEndian`=1, either form asserts `alignExc` together with `done`, issues no memory request and writes no register.
- R9: An indexed count of 0 writes no register and asserts `done` in the cycle after the start cycle.
- R10: `done` is a one-cycle pulse. `busy` is high from the cycle after start up to and including the `done` cycle. `start` is only accepted while not busy.
- R11: The effective address and the protected register number are captured at start. Changes to `raVal`/`rbVal` afterwards do not affect the addresses used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (one cycle) |
| formIdx | input | 1 | 0 immediate form, 1 indexed form |
| rtIdx | input | 5 | First target register |
| raIdx | input | 5 | Base register number |
| rbIdx | input | 5 | Index register number |
| immCount | input | 5 | Immediate byte count (0 means 32) |
| xerCount | input | 7 | Indexed byte count |
| raVal | input | 64 | Value of base register |
| rbVal | input | 64 | Value of index register |
| littleEndian | input | 1 | Current endian mode, 1 = little |
| memReq | output | 1 | Byte read request |
| memAddr | output | 64 | Byte address of request |
| memRspValid | input | 1 | Read response valid |
| memData | input | 8 | Read response byte |
| regWe | output | 1 | Register write enable |
| regWaddr | output | 5 | Register write index |
| regWdata | output | 64 | Register write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished (one cycle) |
| alignExc | output | 1 | Alignment exception, valid with done |

## Verification
The hardest case to reach from the ports is a word that wraps past register 31 and lands on the protected register. The bench gets there by starting at register 31 with a count long enough for three words, and by choosing the base (immediate form) or the index (indexed form) as register 1 or 0. It then checks that the writes on either side of the protected register still arrive with the right data. Each run also overwrites `raVal` and `rbVal` right after start. A memory model that returns address-dependent bytes would then expose any addressing that does not use the captured value.

// File: rtl/strload_pkg.sv
package strload_pkg;
  localparam int XLEN = 64;
  localparam int IDX_W = 5;
  localparam int CNT_W = 7;
  localparam int WORD_W = 32;
  localparam int IMM_W = 5;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_FIN} seqState_t;

  typedef struct packed {
    logic load;
    logic take;
  } seqStrobe_t;
endpackage

// File: rtl/strload_dp.sv
module strload_dp
  import strload_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic             formIdx,
  input  logic [IDX_W-1:0] rtIdx,
  input  logic [IDX_W-1:0] raIdx,
  input  logic [IDX_W-1:0] rbIdx,
  input  logic [IMM_W-1:0] immCount,
  input  logic [CNT_W-1:0] xerCount,
  input  logic [XLEN-1:0]  raVal,
  input  logic [XLEN-1:0]  rbVal,
  input  logic             littleEndian,
  input  logic [7:0]       memData,
  output logic             startZero,
  output logic             startExc,
  output logic             lastByte,
  output logic             writeOk,
  output logic             excFlag,
  output logic [XLEN-1:0]  memAddr,
  output logic [IDX_W-1:0] regWaddr,
  output logic [XLEN-1:0]  regWdata
);
  localparam int LANES = WORD_W / 8;
  localparam int LANE_W = $clog2(LANES);

  logic [XLEN-1:0]   eaQ;
  logic [CNT_W-1:0]  cntQ, takenQ;
  logic [IDX_W-1:0]  curQ, protQ;
  logic              protEnQ, excQ;
  logic [WORD_W-1:0] wordQ, merged;
  logic [CNT_W-1:0]  startCount;
  logic [XLEN-1:0]   startEa;
  logic [LANE_W-1:0] lane;
  logic              wordEnd;

  always_comb begin
    if (formIdx) startCount = xerCount;
    else if (immCount == '0) startCount = CNT_W'(32);
    else startCount = CNT_W'(immCount);
    startEa = ((raIdx == '0) ? '0 : raVal) + (formIdx ? rbVal : '0);
  end

  assign startZero = (startCount == '0);
  assign startExc  = littleEndian;

  assign lane     = takenQ[LANE_W-1:0];
  assign merged   = wordQ | ({{(WORD_W-8){1'b0}}, memData} << {(LANE_W'(LANES-1) - lane), 3'b000});
  assign lastByte = ((takenQ + CNT_W'(1)) == cntQ);
  assign wordEnd  = (lane == LANE_W'(LANES-1)) || lastByte;
  assign writeOk  = wordEnd && !(protEnQ && (curQ == protQ));
  assign excFlag  = excQ;
  assign memAddr  = eaQ;
  assign regWaddr = curQ;
  assign regWdata = {{(XLEN-WORD_W){1'b0}}, merged};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eaQ     <= '0;
      cntQ    <= '0;
      takenQ  <= '0;
      curQ    <= '0;
      protQ   <= '0;
      protEnQ <= 1'b0;
      excQ    <= 1'b0;
      wordQ   <= '0;
    end else if (strobe.load) begin
      eaQ     <= startEa;
      cntQ    <= startCount;
      takenQ  <= '0;
      curQ    <= rtIdx;
      protQ   <= formIdx ? rbIdx : raIdx;
      protEnQ <= formIdx || (raIdx != '0);
      excQ    <= littleEndian;
      wordQ   <= '0;
    end else if (strobe.take) begin
      eaQ    <= eaQ + XLEN'(1);
      takenQ <= takenQ + CNT_W'(1);
      if (wordEnd) begin
        wordQ <= '0;
        curQ  <= curQ + IDX_W'(1);
      end else begin
        wordQ <= merged;
      end
    end
  end
endmodule

// File: rtl/strload_ctl.sv
module strload_ctl
  import strload_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       startZero,
  input  logic       startExc,
  input  logic       lastByte,
  input  logic       writeOk,
  input  logic       excFlag,
  input  logic       memRspValid,
  output seqStrobe_t strobe,
  output logic       memReq,
  output logic       regWe,
  output logic       busy,
  output logic       done,
  output logic       alignExc
);
  seqState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      S_IDLE: if (start) stateD = (startExc || startZero) ? S_FIN : S_REQ;
      S_REQ:  stateD = S_WAIT;
      S_WAIT: if (memRspValid) stateD = lastByte ? S_FIN : S_REQ;
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= S_IDLE;
    else stateQ <= stateD;
  end

  assign strobe.load = (stateQ == S_IDLE) && start;
  assign strobe.take = (stateQ == S_WAIT) && memRspValid;
  assign regWe    = strobe.take && writeOk;
  assign memReq   = (stateQ == S_REQ);
  assign busy     = (stateQ != S_IDLE);
  assign done     = (stateQ == S_FIN);
  assign alignExc = done && excFlag;
endmodule

// File: rtl/strload_seq.sv
module strload_seq
  import strload_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        formIdx,
  input  logic [4:0]  rtIdx,
  input  logic [4:0]  raIdx,
  input  logic [4:0]  rbIdx,
  input  logic [4:0]  immCount,
  input  logic [6:0]  xerCount,
  input  logic [63:0] raVal,
  input  logic [63:0] rbVal,
  input  logic        littleEndian,
  output logic        memReq,
  output logic [63:0] memAddr,
  input  logic        memRspValid,
  input  logic [7:0]  memData,
  output logic        regWe,
  output logic [4:0]  regWaddr,
  output logic [63:0] regWdata,
  output logic        busy,
  output logic        done,
  output logic        alignExc
);
  seqStrobe_t strobe;
  logic startZero, startExc, lastByte, writeOk, excFlag;

  strload_ctl u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .startZero(startZero),
    .startExc(startExc), .lastByte(lastByte), .writeOk(writeOk),
    .excFlag(excFlag), .memRspValid(memRspValid), .strobe(strobe),
    .memReq(memReq), .regWe(regWe), .busy(busy), .done(done),
    .alignExc(alignExc)
  );

  strload_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .formIdx(formIdx),
    .rtIdx(rtIdx), .raIdx(raIdx), .rbIdx(rbIdx), .immCount(immCount),
    .xerCount(xerCount), .raVal(raVal), .rbVal(rbVal),
    .littleEndian(littleEndian), .memData(memData),
    .startZero(startZero), .startExc(startExc), .lastByte(lastByte),
    .writeOk(writeOk), .excFlag(excFlag), .memAddr(memAddr),
    .regWaddr(regWaddr), .regWdata(regWdata)
  );
endmodule

// File: rtl/strload_chk.sv
module strload_chk (
  input logic        clk,
  input logic        rstN,
  input logic        memReq,
  input logic        regWe,
  input logic [63:0] regWdata,
  input logic        busy,
  input logic        done,
  input logic        alignExc
);
  a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r10_busy_at_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);
  a_r6_write_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> busy && !done);
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> (regWdata[63:32] == 32'h0));
  a_r8_exc_with_done: assert property (@(posedge clk) disable iff (!rstN)
    alignExc |-> done && !memReq && !regWe);
endmodule

bind strload_seq strload_chk u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .regWe(regWe),
  .regWdata(regWdata), .busy(busy), .done(done), .alignExc(alignExc)
);

// File: tb/strload_seq_bench.sv
module strload_seq_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        formIdx = 1'b0;
  logic [4:0]  rtIdx = '0, raIdx = '0, rbIdx = '0, immCount = '0;
  logic [6:0]  xerCount = '0;
  logic [63:0] raVal = '0, rbVal = '0;
  logic        littleEndian = 1'b0;
  logic        memReq, memRspValid = 1'b0;
  logic [63:0] memAddr;
  logic [7:0]  memData = '0;
  logic        regWe, busy, done, alignExc;
  logic [4:0]  regWaddr;
  logic [63:0] regWdata;

  int checks = 0;
  int failures = 0;
  logic [68:0] expQ[$];
  logic [63:0] base = 64'h2000;

  always #10 clk = ~clk;

  strload_seq u_strload_seq (.*);

  // memory model: byte at base+k reads as k+1
  always @(posedge clk) begin
    memRspValid <= memReq;
    memData     <= memReq ? 8'(memAddr - base + 64'd1) : 8'h00;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && regWe) begin
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL R6: unexpected write r%0d=%h, expected none", regWaddr, regWdata);
      end else begin
        logic [68:0] e;
        e = expQ.pop_front();
        if ({regWaddr, regWdata} !== e) begin
          failures++;
          $display("FAIL R3/R5/R7: write r%0d=%h, expected r%0d=%h",
                   regWaddr, regWdata, e[68:64], e[63:0]);
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // pushes expected writes and runs one operation
  task automatic runOp(input bit form, input logic [4:0] rt, input logic [4:0] ra,
                       input logic [4:0] rb, input logic [4:0] imm, input logic [6:0] xer,
                       input logic [63:0] raV, input logic [63:0] rbV, input bit le,
                       input string tag);
    int n, cyc;
    logic [4:0] r, prot;
    bit protEn;
    n = form ? int'(xer) : ((imm == 0) ? 32 : int'(imm));
    prot = form ? rb : ra;
    protEn = form || (ra != 0);
    r = rt;
    if (!le) begin
      for (int w = 0; w < (n + 3) / 4; w++) begin
        logic [31:0] word;
        word = '0;
        for (int j = 0; j < 4; j++)
          if (4 * w + j < n) word[31 - 8*j -: 8] = 8'(4 * w + j + 1);
        if (!(protEn && r == prot)) expQ.push_back({r, 32'h0, word});
        r = r + 5'd1;
      end
    end
    formIdx = form; rtIdx = rt; raIdx = ra; rbIdx = rb; immCount = imm;
    xerCount = xer; raVal = raV; rbVal = rbV; littleEndian = le; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    raVal = 64'hDEAD_0000_0000_0000;   // R11: later changes must not matter
    rbVal = 64'h0BAD_0000_0000_0000;
    cyc = 1;
    check(busy === 1'b1, {tag, " R10 busy after start"}, 64'(busy), 64'd1);
    while (done !== 1'b1 && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    check(done === 1'b1 && busy === 1'b1, {tag, " R10 done with busy"}, 64'(done), 64'd1);
    check(alignExc === le, {tag, " R8 alignExc"}, 64'(alignExc), 64'(le));
    check(expQ.size() == 0, {tag, " R6 all expected writes seen"}, 64'(expQ.size()), 64'd0);
    if (le || (form && xer == 0))
      check(cyc == 1, {tag, " R8/R9 done in cycle after start"}, 64'(cyc), 64'd1);
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, {tag, " R10 done one cycle"}, 64'(done), 64'd0);
    expQ.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // memory requests must never occur for little-endian runs (R8)
  bit leRun = 1'b0;
  always @(negedge clk)
    if (leRun && memReq) begin
      checks++;
      failures++;
      $display("FAIL R8: memReq=1 expected 0");
    end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy === 0 && done === 0 && regWe === 0 && memReq === 0, "reset R10",
          {60'h0, busy, done, regWe, memReq}, 64'h0);
    // R1 R4: immediate, 3 bytes
    runOp(1'b0, 5'd11, 5'd5, 5'd0, 5'd3, 7'd0, base, 64'h0, 1'b0, "imm3 R1 R4");
    // R1: immediate 0 means 32 bytes, r11..r18 only (R6)
    runOp(1'b0, 5'd11, 5'd5, 5'd0, 5'd0, 7'd0, base, 64'h0, 1'b0, "imm32 R1 R6");
    // R5: wrap 31 -> 0
    runOp(1'b0, 5'd31, 5'd5, 5'd0, 5'd8, 7'd0, base, 64'h0, 1'b0, "immwrap R5");
    // R7: base register r1 skipped after wrap
    runOp(1'b0, 5'd31, 5'd1, 5'd0, 5'd10, 7'd0, base, 64'h0, 1'b0, "immprot R7");
    // R2: indexed, ra=0, partial
    runOp(1'b1, 5'd11, 5'd0, 5'd7, 5'd0, 7'd3, 64'h5555, base, 1'b0, "idx3 R2 R4");
    // R2: indexed with nonzero base, 32 bytes
    runOp(1'b1, 5'd11, 5'd4, 5'd7, 5'd0, 7'd32, 64'h1000, 64'h1000, 1'b0, "idx32 R2 R6");
    // R7: index register r0 skipped, r1 written
    runOp(1'b1, 5'd31, 5'd0, 5'd0, 5'd0, 7'd12, 64'h0, base, 1'b0, "idxprot R7 R5");
    // R9: zero indexed count
    runOp(1'b1, 5'd11, 5'd0, 5'd7, 5'd0, 7'd0, 64'h0, base, 1'b0, "idx0 R9");
    // R8: little-endian, both forms
    leRun = 1'b1;
    runOp(1'b0, 5'd11, 5'd5, 5'd0, 5'd4, 7'd0, base, 64'h0, 1'b1, "leimm R8");
    runOp(1'b1, 5'd12, 5'd0, 5'd11, 5'd0, 7'd4, 64'h0, base, 1'b1, "leidx R8");
    leRun = 1'b0;
    // R11 R3: unaligned odd count with base changed right after start
    runOp(1'b0, 5'd2, 5'd9, 5'd0, 5'd7, 7'd0, base, 64'h0, 1'b0, "imm7 R11 R3");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule